// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits between a group of lanes and a scratchpad built from independent single-port banks. Each lane offers one word address per request, and a mask says which lanes take part. Each bank can serve one row per cycle, so the block works out which lanes collide. It drives the bank read ports pass by pass until every active lane has its word. It then returns all the lane words at once with a one-cycle `done` pulse. Lanes asking for the same stored word share one bank read. Any number of such shared groups in different banks are served in the same pass.

Two bank-word modes are supported and chosen per request by `wide_mode`. In narrow mode a bank holds 32-bit words: the low bits of the word address pick the bank and the rest pick the row. In wide mode a bank entry is 64 bits wide and holds two consecutive words. Both words of an entry come out in the same bank read, so two lanes that touch either half of one entry count as one access.

The request side is a valid/ready input. A request moves on the rising edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the cycle in which `done` is high, so a source holding `in_valid` is stalled while the request is served. The returned data has no back-pressure: the consumer must take `lane_data` in the `done` cycle, or before the next request is accepted. The bank ports expect a registered read: data for a row requested in one cycle is presented on `bank_rd_data` in the next cycle.

Top module: `scratch_bank_arb`

## Requirements
- R1: In narrow mode (`wide_mode` = 0), a lane's bank is address bits [4:0], its bank row is the address shifted right by 5, and its word is bits [31:0] of that bank's read data.
- R2: In wide mode (`wide_mode` = 1), a lane's bank is address bits [5:1] and its bank row is the address shifted right by 6. Address bit 0 chooses the half of the 64-bit bank data: 0 gives bits [31:0] and 1 gives bits [63:32].
- R3: The number of passes P is the largest count of distinct bank rows that active lanes request in any one bank. `done` is high in the cycle after the (P+1)-th rising edge that follows the accepting edge. No bank read is issued in the cycle before `done`.
- R4: Active lanes that request the same row of the same bank cost a single pass together. In narrow mode that means the same address; in wide mode it means the same address with bit 0 ignored.
- R5: Groups of lanes sharing a row in different banks are all served in the same pass.
- R6: Within one bank, each pass reads the row wanted by the lowest-numbered active lane that has not yet been served.
- R7: Inactive lanes (mask bit 0) cause no bank read and no extra pass, and their `lane_data` field reads zero at `done`.
- R8: `in_ready` is high while idle, goes low on the edge that accepts a request, and is high again in the `done` cycle, where a new request may be accepted.
- R9: `done` is a single-cycle pulse. `lane_data` is valid in that cycle and holds its value until the next request is accepted.
- R10: After reset `in_ready` is 1, `done` is 0 and no bank read enable is set. No bank read is issued while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | Bank-word mode, sampled with the request: 0 for 32-bit, 1 for 64-bit |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block can take a request |
| in_mask | input | LANES | Active-lane mask, bit i for lane i |
| in_addr | input | LANES*ADDR_W | Word address per lane, lane i at bits [i*ADDR_W +: ADDR_W] |
| bank_rd_en | output | BANKS | Read enable per bank |
| bank_rd_row | output | BANKS*ROW_W | Row per bank, bank b at bits [b*ROW_W +: ROW_W] |
| bank_rd_data | input | BANKS*2*DATA_W | Registered read data per bank, one cycle after the enable |
| done | output | 1 | One-cycle pulse when all active lanes hold their word |
| lane_data | output | LANES*DATA_W | Returned word per lane, lane i at bits [i*DATA_W +: DATA_W] |

## Verification
The bench builds the block with its defaults: 32 lanes, 32 banks, 12-bit word addresses and 32-bit words, with a 64-bit bank entry. With these values, 32 active lanes can hit all 32 banks. This exposes the classic access shapes: unit stride, stride 2 in both modes, stride 3, a full broadcast, two broadcast groups in separate banks, and the worst case of all 32 lanes in one bank needing 32 passes. The 12-bit address leaves enough rows to make every one of those collisions distinct. The bank model returns a word that depends on the address, so a wrong bank, row or half shows up in the data.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } sbc_state_e;

endpackage

// File: rtl/sbc_lane_map.sv
module sbc_lane_map #(
  parameter int ADDR_W = 12,
  parameter int BW     = 5,
  parameter int ROW_W  = ADDR_W - BW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic [BW-1:0]     bank,
  output logic [ROW_W-1:0]  row,
  output logic              hi
);

  always_comb begin
    if (wide) begin
      bank = addr[BW:1];
      row  = {1'b0, addr[ADDR_W-1:BW+1]};
      hi   = addr[0];
    end else begin
      bank = addr[BW-1:0];
      row  = addr[ADDR_W-1:BW];
      hi   = 1'b0;
    end
  end

endmodule

// File: rtl/sbc_pass_pick.sv
module sbc_pass_pick #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int BW    = 5,
  parameter int ROW_W = 7
) (
  input  logic [LANES-1:0] pending,
  input  logic [BW-1:0]    bank [LANES],
  input  logic [ROW_W-1:0] row  [LANES],
  output logic [LANES-1:0] served,
  output logic [BANKS-1:0] rd_en,
  output logic [ROW_W-1:0] rd_row [BANKS]
);

  // A lane is served when the first pending lane in its bank wants the same row.
  always_comb begin
    logic found;
    logic same;
    for (int i = 0; i < LANES; i++) begin
      found = 1'b0;
      same  = 1'b0;
      for (int j = 0; j <= i; j++) begin
        if (!found && pending[j] && (bank[j] == bank[i])) begin
          found = 1'b1;
          same  = (row[j] == row[i]);
        end
      end
      served[i] = pending[i] && same;
    end
  end

  // Per bank, the row of the lowest pending lane is issued.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      rd_en[b]  = 1'b0;
      rd_row[b] = '0;
      for (int j = LANES - 1; j >= 0; j--) begin
        if (pending[j] && (bank[j] == BW'(b))) begin
          rd_en[b]  = 1'b1;
          rd_row[b] = row[j];
        end
      end
    end
  end

endmodule

// File: rtl/sbc_gather.sv
module sbc_gather #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int BW     = 5,
  parameter int DATA_W = 32,
  localparam int BANK_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [LANES-1:0]  cap,
  input  logic [BW-1:0]     bank      [LANES],
  input  logic [LANES-1:0]  hi,
  input  logic [BANK_W-1:0] bank_word [BANKS],
  output logic [DATA_W-1:0] word      [LANES]
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < LANES; i++) word[i] <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (cap[i]) begin
          word[i] <= hi[i] ? bank_word[bank[i]][BANK_W-1:DATA_W]
                           : bank_word[bank[i]][DATA_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/scratch_bank_arb.sv
module scratch_bank_arb
  import sbc_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int BW     = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BW,
  localparam int BANK_W = 2 * DATA_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wide_mode,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES-1:0]          in_mask,
  input  logic [LANES*ADDR_W-1:0]   in_addr,
  output logic [BANKS-1:0]          bank_rd_en,
  output logic [BANKS*ROW_W-1:0]    bank_rd_row,
  input  logic [BANKS*BANK_W-1:0]   bank_rd_data,
  output logic                      done,
  output logic [LANES*DATA_W-1:0]   lane_data
);

  sbc_state_e        st_q;
  logic              wide_q;
  logic              done_q;
  logic [LANES-1:0]  pend_q;
  logic [LANES-1:0]  cap_q;
  logic [LANES-1:0]  served;
  logic              accept;
  logic [ADDR_W-1:0] addr_q    [LANES];
  logic [BW-1:0]     lane_bank [LANES];
  logic [ROW_W-1:0]  lane_row  [LANES];
  logic [LANES-1:0]  lane_hi;
  logic [BANKS-1:0]  pick_en;
  logic [ROW_W-1:0]  pick_row  [BANKS];
  logic [BANK_W-1:0] bank_word [BANKS];
  logic [DATA_W-1:0] lane_word [LANES];

  assign in_ready = (st_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) addr_q[i] <= '0;
    end else if (accept) begin
      for (int i = 0; i < LANES; i++) addr_q[i] <= in_addr[i*ADDR_W +: ADDR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      wide_q <= 1'b0;
      pend_q <= '0;
      cap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            wide_q <= wide_mode;
            pend_q <= in_mask;
            cap_q  <= '0;
            st_q   <= ST_SERVE;
          end
        end
        default: begin
          cap_q  <= served;
          pend_q <= pend_q & ~served;
          if (pend_q == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbc_lane_map #(
      .ADDR_W(ADDR_W), .BW(BW), .ROW_W(ROW_W)
    ) u_map (
      .addr (addr_q[g]),
      .wide (wide_q),
      .bank (lane_bank[g]),
      .row  (lane_row[g]),
      .hi   (lane_hi[g])
    );
    assign lane_data[g*DATA_W +: DATA_W] = lane_word[g];
  end

  sbc_pass_pick #(
    .LANES(LANES), .BANKS(BANKS), .BW(BW), .ROW_W(ROW_W)
  ) u_pick (
    .pending (pend_q),
    .bank    (lane_bank),
    .row     (lane_row),
    .served  (served),
    .rd_en   (pick_en),
    .rd_row  (pick_row)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_rd_en[b]                  = (st_q == ST_SERVE) && pick_en[b];
    assign bank_rd_row[b*ROW_W +: ROW_W]  = pick_row[b];
    assign bank_word[b]                   = bank_rd_data[b*BANK_W +: BANK_W];
  end

  sbc_gather #(
    .LANES(LANES), .BANKS(BANKS), .BW(BW), .DATA_W(DATA_W)
  ) u_gather (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .cap       (cap_q),
    .bank      (lane_bank),
    .hi        (lane_hi),
    .bank_word (bank_word),
    .word      (lane_word)
  );

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int LANES = 32,
  parameter int BANKS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done,
  input logic [BANKS-1:0] bank_rd_en
);

  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || in_ready) busy_cnt <= 0;
    else                 busy_cnt <= busy_cnt + 1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);

  assert_accept_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (bank_rd_en == '0));

  assert_drain_gap_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(bank_rd_en) == '0));

  assert_pass_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= LANES + 1);

endmodule

bind scratch_bank_arb sbc_checker #(
  .LANES(LANES), .BANKS(BANKS)
) u_sbc_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .done       (done),
  .bank_rd_en (bank_rd_en)
);

// File: tb/scratch_bank_arb_bench.sv
module scratch_bank_arb_bench;

  localparam int LANES  = 32;
  localparam int BANKS  = 32;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int BW     = 5;
  localparam int ROW_W  = ADDR_W - BW;
  localparam int BANK_W = 2 * DATA_W;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    wide_mode = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic [LANES-1:0]        in_mask = '0;
  logic [LANES*ADDR_W-1:0] in_addr = '0;
  logic [BANKS-1:0]        bank_rd_en;
  logic [BANKS*ROW_W-1:0]  bank_rd_row;
  logic [BANKS*BANK_W-1:0] bank_rd_data = '0;
  logic                    done;
  logic [LANES*DATA_W-1:0] lane_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic mdl_wide = 1'b0;
  logic [ADDR_W-1:0] req_addr [LANES];

  logic [LANES*DATA_W-1:0] exp_q [$];
  int                      pass_q [$];
  int                      acc_q [$];
  string                   tag_q [$];
  logic                    ready_bad = 1'b0;

  always #10 clk = ~clk;

  scratch_bank_arb #(
    .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_scratch_bank_arb (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_mask(in_mask), .in_addr(in_addr),
    .bank_rd_en(bank_rd_en), .bank_rd_row(bank_rd_row),
    .bank_rd_data(bank_rd_data), .done(done), .lane_data(lane_data)
  );

  function automatic logic [DATA_W-1:0] word_of(input int a);
    logic [15:0] s;
    s = 16'(a);
    return {s ^ 16'hC3A5, s};
  endfunction

  // bank memory model with registered read
  always @(posedge clk) begin
    if (in_valid && in_ready) mdl_wide <= wide_mode;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_rd_en[b]) begin
        int e;
        e = int'(bank_rd_row[b*ROW_W +: ROW_W]) * BANKS + b;
        if (mdl_wide) bank_rd_data[b*BANK_W +: BANK_W] <= {word_of(2*e+1), word_of(2*e)};
        else          bank_rd_data[b*BANK_W +: BANK_W] <= {~word_of(e), word_of(e)};
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_passes(input logic [LANES-1:0] m, input logic w);
    int cnt [BANKS];
    int best;
    best = 0;
    for (int b = 0; b < BANKS; b++) cnt[b] = 0;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        int ki;
        bit seen;
        ki = w ? int'(req_addr[i]) / 2 : int'(req_addr[i]);
        seen = 0;
        for (int j = 0; j < i; j++) begin
          int kj;
          kj = w ? int'(req_addr[j]) / 2 : int'(req_addr[j]);
          if (m[j] && kj == ki) seen = 1;
        end
        if (!seen) cnt[ki % BANKS]++;
      end
    end
    for (int b = 0; b < BANKS; b++) if (cnt[b] > best) best = cnt[b];
    return best;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: offers a request, pushes expected result on acceptance
  task automatic send(input logic [LANES-1:0] m, input logic w, input string tag);
    logic [LANES*DATA_W-1:0] exp;
    int acc;
    @(negedge clk);
    wide_mode = w;
    in_mask   = m;
    for (int i = 0; i < LANES; i++) in_addr[i*ADDR_W +: ADDR_W] = req_addr[i];
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    acc = cyc + 1;
    for (int i = 0; i < LANES; i++)
      exp[i*DATA_W +: DATA_W] = m[i] ? word_of(int'(req_addr[i])) : '0;
    @(posedge clk);
    exp_q.push_back(exp);
    pass_q.push_back(exp_passes(m, w));
    acc_q.push_back(acc);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && exp_q.size() != 0) begin
      if (!done) begin
        if (in_ready) ready_bad = 1'b1;
      end else begin
        logic [LANES*DATA_W-1:0] e;
        int p, a;
        string t;
        e = exp_q.pop_front();
        p = pass_q.pop_front();
        a = acc_q.pop_front();
        t = tag_q.pop_front();
        if (lane_data !== e) begin
          for (int i = 0; i < LANES; i++)
            if (lane_data[i*DATA_W +: DATA_W] !== e[i*DATA_W +: DATA_W]) begin
              $display("  %s lane %0d differs", t, i);
              break;
            end
        end
        check(lane_data === e, t, "lane data", lane_data[63:0], e[63:0]);
        check(cyc - a == p + 1, "R3", {t, " done latency"}, cyc - a, p + 1);
        check(!ready_bad, "R8", {t, " ready low while busy"}, ready_bad, 0);
        ready_bad = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [LANES*DATA_W-1:0] held;
    for (int i = 0; i < LANES; i++) req_addr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(in_ready === 1'b1, "R10", "ready after reset", in_ready, 1);
    check(done === 1'b0, "R10", "done after reset", done, 0);
    check(bank_rd_en === '0, "R10", "no reads after reset", bank_rd_en, 0);

    // R1: unit stride, narrow, one pass
    for (int i = 0; i < LANES; i++) req_addr[i] = ADDR_W'(100 + i);
    send('1, 1'b0, "R1");
    // R3: stride 2 narrow, two passes (held back-to-back)
    for (int i = 0; i < LANES; i++) req_addr[i] = ADDR_W'(2 * i + 64);
    send('1, 1'b0, "R3");
    // R2: stride 2 wide, one pass
    send('1, 1'b1, "R2");
    // R1: stride 3 narrow, no conflict
    for (int i = 0; i < LANES; i++) req_addr[i] = ADDR_W'(3 * i + 7);
    send('1, 1'b0, "R1");
    // R4: every lane same word
    for (int i = 0; i < LANES; i++) req_addr[i] = ADDR_W'(1234);
    send('1, 1'b0, "R4");
    // R5: two groups in banks 12 and 20
    for (int i = 0; i < LANES; i++)
      req_addr[i] = (i % 2 == 0) ? ADDR_W'(3 * 32 + 12) : ADDR_W'(7 * 32 + 20);
    send('1, 1'b0, "R5");
    // R3: all lanes in bank 5, distinct rows, 32 passes
    for (int i = 0; i < LANES; i++) req_addr[i] = ADDR_W'(i * 32 + 5);
    send('1, 1'b0, "R3");
    // R7: empty mask
    send('0, 1'b0, "R7");
    // R7: inactive odd lanes would collide in bank 0
    for (int i = 0; i < LANES; i++)
      req_addr[i] = (i % 2 == 0) ? ADDR_W'(i + 512) : ADDR_W'(i * 32);
    send(32'h5555_5555, 1'b0, "R7");
    // R4 and R2: wide, lane pairs share an entry, odd halves
    for (int i = 0; i < LANES; i++) req_addr[i] = ADDR_W'(i + 2048);
    send('1, 1'b1, "R4");
    // R2: wide with a mix of entries colliding in bank 3
    for (int i = 0; i < LANES; i++)
      req_addr[i] = (i < 8) ? ADDR_W'(i * 64 + 6 + (i % 2)) : ADDR_W'(i * 2 + 1);
    send('1, 1'b1, "R2");
    // pseudo-random patterns in both modes
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < LANES; i++)
        req_addr[i] = ADDR_W'((i * 37 + r * 411 + (i * i) * (r + 1)) % 4096);
      send(32'hFFFF_FFFF ^ (32'h1 << r * 5), r[0], "R3");
    end
    drain();

    // R6: bank 7, lane 1 wants row 9, lane 3 wants row 5, lane 0 inactive
    for (int i = 0; i < LANES; i++) req_addr[i] = ADDR_W'(i + 32 * 60);
    req_addr[0] = ADDR_W'(2 * 32 + 7);
    req_addr[1] = ADDR_W'(9 * 32 + 7);
    req_addr[3] = ADDR_W'(5 * 32 + 7);
    send(32'hFFFF_FFFE, 1'b0, "R6");
    @(negedge clk);
    check(bank_rd_en[7] === 1'b1 && bank_rd_row[7*ROW_W +: ROW_W] === ROW_W'(9),
          "R6", "first row in bank 7", bank_rd_row[7*ROW_W +: ROW_W], 9);
    @(negedge clk);
    check(bank_rd_en[7] === 1'b1 && bank_rd_row[7*ROW_W +: ROW_W] === ROW_W'(5),
          "R6", "second row in bank 7", bank_rd_row[7*ROW_W +: ROW_W], 5);
    drain();

    // R9: data held, done low after the pulse
    held = lane_data;
    repeat (3) @(negedge clk);
    check(lane_data === held, "R9", "data held after done", lane_data[63:0], held[63:0]);
    check(done === 1'b0, "R9", "done single pulse", done, 0);
    check(bank_rd_en === '0, "R10", "idle no reads", bank_rd_en, 0);

    finish_run();
  end

endmodule